// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Adder

This unit adds or subtracts two 32-bit binary floating-point words. Each word carries a sign bit in bit 31 (1 for negative), an 8-bit exponent in bits 30:23 stored with a bias of 127, and a 23-bit fraction in bits 22:0. For nonzero finite values the significand is the fraction with an implicit leading 1 restored. The operation runs through four registered stages. Stage one lines up the binary points by shifting the smaller operand right. Stage two adds or subtracts the significands according to their signs. Stage three normalizes the sum and checks the exponent range. Stage four rounds to nearest even and renormalizes if the rounding carries out.

A caller presents two operands, a subtract select and a valid strobe in any cycle, with no gaps required. The result word comes out exactly four clock edges later, together with overflow and underflow flags. Exponent-zero inputs count as zero. Results too small to normalize are flushed to a signed zero.

Top module: `fpadd_pipe`

## Requirements
- R1: An operation accepted on a rising edge with `inValid` high has `outValid` high, and its result, after exactly the fourth following rising edge. Operations may be issued on consecutive cycles, and results leave in issue order.
- R2: While `rstN` is low, and after its release until the first accepted operation has passed through, `outValid` is low.
- R3: For finite normal operands the result is the exact sum rounded to nearest. For example 0x3F000000 (0.5) plus 0xBEE00000 (-0.4375) gives 0x3D800000 (0.0625) with both flags low.
- R4: With `subSel` high the result equals `opA` plus `opB` with the sign bit of `opB` inverted.
- R5: Rounding is to nearest with ties to even. A rounding carry out of the significand increments the exponent, so 0x3FFFFFFF + 0x33800000 gives 0x40000000.
- R6: An exact zero sum gives 0x00000000, except that the sum of two negative zeros gives 0x80000000.
- R7: If the exponent after normalizing or rounding reaches 255, the result is infinity with the sign of the exact sum, and `overflow` is high.
- R8: Operands whose exponent field is 0 count as zero. A nonzero sum whose normalized exponent, taken before rounding, is 0 or below gives a zero carrying the sign of the exact sum, and `underflow` is high.
- R9: An exponent field of 255 marks infinity (fraction zero) or NaN (fraction nonzero). A NaN in `opA`, or otherwise in `opB`, is returned with fraction bit 22 set. Infinities of opposite effective sign give 0x7FC00000. Otherwise an infinity is returned with its effective sign. No flag is raised in any of these cases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset of the valid pipeline |
| inValid | input | 1 | Operands and select are valid this cycle |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| subSel | input | 1 | 1 selects opA minus opB |
| outValid | output | 1 | result and flags are valid |
| result | output | 32 | Rounded sum or difference |
| overflow | output | 1 | Result saturated to infinity |
| underflow | output | 1 | Result flushed to zero |

## Verification
The bench first targets the rounding corners. These are an exact tie, which rounds to the even neighbour, and a tie that rounds up and carries out of the significand. A design that rounded ties away from zero, or that failed to renormalize after the carry, would return a result off by one unit in the last place, or with the wrong exponent. Massive cancellation, such as the 0.5 minus 0.4375 case and equal operands with opposite signs, would expose a leading-zero count that is off by one or a negative-zero sign rule applied wrongly. Operands far apart in exponent test the sticky collection during alignment. Results at the largest and smallest exponent, plus infinities and NaNs, test the flag and saturation paths: a faulty design would wrap the exponent or leave a flag silent.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int EXT_W   = SIG_W + 3;
  localparam int SUM_W   = EXT_W + 1;
  localparam int XEXP_W  = EXP_W + 2;
  localparam int LZ_W    = $clog2(EXT_W + 1);
  localparam int DEPTH   = 4;
  localparam logic [EXP_W-1:0] EXP_MAX = '1;

  typedef struct packed {
    logic [DEPTH-1:0] load;
    logic             done;
  } strobe_t;
endpackage

// File: rtl/fpadd_ctrl.sv
module fpadd_ctrl
  import fpadd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output strobe_t strobes
);
  logic [DEPTH-1:0] vPipe;

  always_ff @(posedge clk) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[DEPTH-2:0], inValid};
  end

  always_comb begin
    strobes.load = {vPipe[DEPTH-2:0], inValid};
    strobes.done = vPipe[DEPTH-1];
  end

  // R1: a result slot is only ever occupied by an operation issued four edges before
  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.done |-> $past(inValid, 4));
  // R2: reset empties the pipeline
  p_reset_empty_r2: assert property (@(posedge clk)
    !rstN |=> !strobes.done);
endmodule

// File: rtl/fpadd_dp.sv
module fpadd_dp
  import fpadd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              subSel,
  output logic [WORD_W-1:0] result,
  output logic              overflow,
  output logic              underflow
);
  localparam int SHW = SIG_W + EXT_W - 1;
  localparam logic [WORD_W-1:0] QUIET_BIT = WORD_W'(1) << (FRAC_W - 1);
  localparam logic [WORD_W-1:0] DEF_NAN   = {1'b0, EXP_MAX, 1'b1, {(FRAC_W-1){1'b0}}};

  function automatic logic [LZ_W-1:0] leadZeros(input logic [EXT_W-1:0] v);
    leadZeros = LZ_W'(EXT_W);
    for (int i = 0; i < EXT_W; i++)
      if (v[i]) leadZeros = LZ_W'(EXT_W - 1 - i);
  endfunction

  // ---------------- stage 1: unpack, specials, align ----------------
  logic aSign, bSign, aNan, bNan, aInf, bInf, swapOps;
  logic [EXP_W-1:0] aExp, bExp, lExp, sExp, expDiff;
  logic [SIG_W-1:0] aSig, bSig, lSig, sSig;
  logic lSign, sSign, spec1;
  logic [WORD_W-1:0] specWord1;
  logic [LZ_W-1:0] shAmt;
  logic [SHW-1:0] shifted;

  always_comb begin
    aSign = opA[WORD_W-1];
    bSign = opB[WORD_W-1] ^ subSel;
    aExp  = opA[WORD_W-2:FRAC_W];
    bExp  = opB[WORD_W-2:FRAC_W];
    aSig  = (aExp == '0) ? '0 : {1'b1, opA[FRAC_W-1:0]};
    bSig  = (bExp == '0) ? '0 : {1'b1, opB[FRAC_W-1:0]};
    aNan  = (aExp == EXP_MAX) && (opA[FRAC_W-1:0] != '0);
    bNan  = (bExp == EXP_MAX) && (opB[FRAC_W-1:0] != '0);
    aInf  = (aExp == EXP_MAX) && !aNan;
    bInf  = (bExp == EXP_MAX) && !bNan;
    spec1 = (aExp == EXP_MAX) || (bExp == EXP_MAX);
    if (aNan)                        specWord1 = opA | QUIET_BIT;
    else if (bNan)                   specWord1 = opB | QUIET_BIT;
    else if (aInf && bInf && (aSign != bSign)) specWord1 = DEF_NAN;
    else if (aInf)                   specWord1 = opA;
    else                             specWord1 = {bSign, opB[WORD_W-2:0]};
    swapOps = opB[WORD_W-2:0] > opA[WORD_W-2:0];
    lSign = swapOps ? bSign : aSign;
    sSign = swapOps ? aSign : bSign;
    lExp  = swapOps ? bExp  : aExp;
    sExp  = swapOps ? aExp  : bExp;
    lSig  = swapOps ? bSig  : aSig;
    sSig  = swapOps ? aSig  : bSig;
    expDiff = lExp - sExp;
    shAmt   = (expDiff > EXP_W'(EXT_W - 2)) ? LZ_W'(EXT_W - 1) : LZ_W'(expDiff);
    shifted = {sSig, {(EXT_W-1){1'b0}}} >> shAmt;
  end

  logic r1Spec, r1LSign, r1SSign;
  logic [WORD_W-1:0] r1Word;
  logic [EXP_W-1:0] r1Exp;
  logic [EXT_W-1:0] r1Big, r1Small;

  always_ff @(posedge clk) begin
    if (strobes.load[0]) begin
      r1Spec  <= spec1;
      r1Word  <= specWord1;
      r1LSign <= lSign;
      r1SSign <= sSign;
      r1Exp   <= lExp;
      r1Big   <= {lSig, 3'b000};
      r1Small <= {shifted[SHW-1:SIG_W], |shifted[SIG_W-1:0]};
    end
  end

  // ---------------- stage 2: signed significand add ----------------
  logic sameSign;
  logic [SUM_W-1:0] sum2;
  always_comb begin
    sameSign = (r1LSign == r1SSign);
    sum2 = sameSign ? ({1'b0, r1Big} + {1'b0, r1Small})
                    : ({1'b0, r1Big} - {1'b0, r1Small});
  end

  logic r2Spec, r2Sign, r2Zero;
  logic [WORD_W-1:0] r2Word;
  logic [EXP_W-1:0] r2Exp;
  logic [SUM_W-1:0] r2Sum;

  always_ff @(posedge clk) begin
    if (strobes.load[1]) begin
      r2Spec <= r1Spec;
      r2Word <= r1Word;
      r2Exp  <= r1Exp;
      r2Sum  <= sum2;
      r2Zero <= (sum2 == '0);
      r2Sign <= (sum2 == '0) ? (sameSign & r1LSign) : r1LSign;
    end
  end

  // ---------------- stage 3: normalize, range check ----------------
  logic [LZ_W-1:0] lz;
  logic [EXT_W-1:0] mant3;
  logic signed [XEXP_W-1:0] exp3;
  always_comb begin
    lz = leadZeros(r2Sum[EXT_W-1:0]);
    if (r2Sum[SUM_W-1]) begin
      mant3 = {r2Sum[SUM_W-1:2], r2Sum[1] | r2Sum[0]};
      exp3  = $signed({2'b00, r2Exp}) + XEXP_W'(1);
    end else begin
      mant3 = r2Sum[EXT_W-1:0] << lz;
      exp3  = $signed({2'b00, r2Exp}) - $signed({{(XEXP_W-LZ_W){1'b0}}, lz});
    end
  end

  logic r3Spec, r3Sign, r3Zero, r3Ovf, r3Unf;
  logic [WORD_W-1:0] r3Word;
  logic [EXT_W-1:0] r3Mant;
  logic signed [XEXP_W-1:0] r3Exp;

  always_ff @(posedge clk) begin
    if (strobes.load[2]) begin
      r3Spec <= r2Spec;
      r3Word <= r2Word;
      r3Sign <= r2Sign;
      r3Zero <= r2Zero;
      r3Mant <= mant3;
      r3Exp  <= exp3;
      r3Ovf  <= !r2Zero && (exp3 >= $signed({2'b00, EXP_MAX}));
      r3Unf  <= !r2Zero && (exp3 <= 0);
    end
  end

  // R3: a nonzero finite sum leaves stage 3 with its leading bit in place
  p_normalized_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load[3] && !r3Spec && !r3Zero) |-> r3Mant[EXT_W-1]);

  // ---------------- stage 4: round to nearest even, pack ----------------
  logic roundUp, carry;
  logic [SIG_W:0] rounded;
  logic signed [XEXP_W-1:0] exp4;
  logic [WORD_W-1:0] word4;
  logic ovf4, unf4;

  always_comb begin
    roundUp = r3Mant[2] & (r3Mant[1] | r3Mant[0] | r3Mant[3]);
    rounded = {1'b0, r3Mant[EXT_W-1:3]} + (SIG_W+1)'(roundUp);
    carry   = rounded[SIG_W];
    exp4    = r3Exp + XEXP_W'(carry);
    ovf4 = 1'b0;
    unf4 = 1'b0;
    if (r3Spec) begin
      word4 = r3Word;
    end else if (r3Zero) begin
      word4 = {r3Sign, {(WORD_W-1){1'b0}}};
    end else if (r3Unf) begin
      word4 = {r3Sign, {(WORD_W-1){1'b0}}};
      unf4  = 1'b1;
    end else if (r3Ovf || exp4 >= $signed({2'b00, EXP_MAX})) begin
      word4 = {r3Sign, EXP_MAX, {FRAC_W{1'b0}}};
      ovf4  = 1'b1;
    end else begin
      word4 = {r3Sign, exp4[EXP_W-1:0],
               carry ? rounded[SIG_W-1:1] : rounded[FRAC_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.load[3]) begin
      result    <= word4;
      overflow  <= ovf4;
      underflow <= unf4;
    end
  end

  // R7 and R8: the two flags never coexist
  p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.done |-> !(overflow && underflow));
  // R7: overflow comes with a saturated infinity
  p_overflow_inf_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.done && overflow) |-> (result[WORD_W-2:0] == {EXP_MAX, {FRAC_W{1'b0}}}));
  // R8: underflow comes with a flushed zero
  p_underflow_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.done && underflow) |-> (result[WORD_W-2:0] == '0));
endmodule

// File: rtl/fpadd_pipe.sv
module fpadd_pipe
  import fpadd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic        subSel,
  output logic        outValid,
  output logic [31:0] result,
  output logic        overflow,
  output logic        underflow
);
  strobe_t strobes;

  fpadd_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes)
  );

  fpadd_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .opA       (opA),
    .opB       (opB),
    .subSel    (subSel),
    .result    (result),
    .overflow  (overflow),
    .underflow (underflow)
  );

  assign outValid = strobes.done;
endmodule

// File: tb/fpadd_pipe_test.sv
module fpadd_pipe_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic subSel = 1'b0;
  logic outValid, overflow, underflow;
  logic [31:0] result;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [33:0] expQ[$];
  int          tgtQ[$];
  string       tagQ[$];

  fpadd_pipe uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .subSel(subSel), .outValid(outValid), .result(result),
    .overflow(overflow), .underflow(underflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Behavioural reference: wide integer alignment with a jam bit, then rounding.
  function automatic longint alignVal(longint m, int d);
    longint base, v;
    base = m <<< 38;
    if (d == 0) return base;
    if (d >= 62) return (m != 0) ? 64'sd1 : 64'sd0;
    v = base >>> d;
    if ((v <<< d) != base) v = v | 64'sd1;
    return v;
  endfunction

  function automatic logic [33:0] refAdd(logic [31:0] a, logic [31:0] b, logic s);
    logic sa, sb, sr;
    int ea, eb, eL, p, e;
    longint ma, mb, tot, mag, keep, rem, half;
    sa = a[31]; sb = b[31] ^ s;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    if (ea == 255 && a[22:0] != 0) return {2'b00, a | 32'h0040_0000};
    if (eb == 255 && b[22:0] != 0) return {2'b00, b | 32'h0040_0000};
    if (ea == 255 && eb == 255 && sa != sb) return {2'b00, 32'h7FC0_0000};
    if (ea == 255) return {2'b00, a};
    if (eb == 255) return {2'b00, sb, b[30:0]};
    ma = (ea == 0) ? 0 : longint'({1'b1, a[22:0]});
    mb = (eb == 0) ? 0 : longint'({1'b1, b[22:0]});
    if (ma == 0 && mb == 0) return {2'b00, sa & sb, 31'b0};
    eL = (ea > eb) ? ea : eb;
    tot = (sa ? -alignVal(ma, eL - ea) : alignVal(ma, eL - ea))
        + (sb ? -alignVal(mb, eL - eb) : alignVal(mb, eL - eb));
    if (tot == 0) return 34'b0;
    sr = (tot < 0);
    mag = sr ? -tot : tot;
    p = 0;
    for (int i = 0; i < 63; i++) if (mag[i]) p = i;
    e = eL + p - 61;
    if (e <= 0) return {2'b01, sr, 31'b0};
    keep = mag >>> (p - 23);
    rem  = mag & ((64'sd1 <<< (p - 23)) - 1);
    half = 64'sd1 <<< (p - 24);
    if (rem > half || (rem == half && keep[0])) keep = keep + 1;
    if (keep == (64'sd1 <<< 24)) begin keep = keep >>> 1; e = e + 1; end
    if (e >= 255) return {2'b10, sr, 8'hFF, 23'b0};
    return {2'b00, sr, 8'(e), keep[22:0]};
  endfunction

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // Output checker: at each falling edge, compare against the expected queue.
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (outValid) begin
        compared++;
        if (expQ.size() == 0) begin
          mismatched++;
          $display("FAIL R1: unexpected outValid, got %h expected none", result);
        end else begin
          logic [33:0] ex;
          int tg;
          string tag;
          ex = expQ.pop_front(); tg = tgtQ.pop_front(); tag = tagQ.pop_front();
          if (tg != cyc) begin
            mismatched++;
            $display("FAIL R1: result in cycle %0d expected cycle %0d", cyc, tg);
          end
          if ({overflow, underflow, result} !== ex) begin
            mismatched++;
            $display("FAIL %s: got %h ovf=%b unf=%b expected %h ovf=%b unf=%b",
                     tag, result, overflow, underflow, ex[31:0], ex[33], ex[32]);
          end
        end
      end else if (expQ.size() != 0 && tgtQ[0] <= cyc) begin
        compared++;
        mismatched++;
        $display("FAIL R1: outValid low in cycle %0d expected high in cycle %0d", cyc, tgtQ[0]);
        void'(expQ.pop_front()); void'(tgtQ.pop_front()); void'(tagQ.pop_front());
      end
    end
  end

  task automatic issue(logic [31:0] a, logic [31:0] b, logic s, logic [33:0] ex, string tag);
    @(negedge clk);
    opA = a; opB = b; subSel = s; inValid = 1'b1;
    expQ.push_back(ex); tgtQ.push_back(cyc + 4); tagQ.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      opA = $urandom; opB = $urandom; subSel = 1'(($urandom));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if (outValid !== 1'b0) begin
      mismatched++;
      $display("FAIL R2: outValid in reset got %b expected 0", outValid);
    end
    rstN = 1'b1;
    idle(5);
    compared++;
    if (outValid !== 1'b0) begin
      mismatched++;
      $display("FAIL R2: outValid after reset got %b expected 0", outValid);
    end

    // back-to-back directed operations
    issue(32'h3F00_0000, 32'hBEE0_0000, 1'b0, {2'b00, 32'h3D80_0000}, "R3");
    issue(32'h3F80_0000, 32'h3F80_0000, 1'b1, {2'b00, 32'h0000_0000}, "R4");
    issue(32'h3F80_0000, 32'h4000_0000, 1'b1, {2'b00, 32'hBF80_0000}, "R4");
    issue(32'h8000_0000, 32'h8000_0000, 1'b0, {2'b00, 32'h8000_0000}, "R6");
    issue(32'h0000_0000, 32'h8000_0000, 1'b0, {2'b00, 32'h0000_0000}, "R6");
    issue(32'hC040_0000, 32'h4040_0000, 1'b0, {2'b00, 32'h0000_0000}, "R6");
    issue(32'h3F80_0000, 32'h3380_0000, 1'b0, {2'b00, 32'h3F80_0000}, "R5");
    issue(32'h3F80_0001, 32'h3380_0000, 1'b0, {2'b00, 32'h3F80_0002}, "R5");
    issue(32'h3FFF_FFFF, 32'h3380_0000, 1'b0, {2'b00, 32'h4000_0000}, "R5");
    issue(32'h7F7F_FFFF, 32'h7F7F_FFFF, 1'b0, {2'b10, 32'h7F80_0000}, "R7");
    issue(32'hFF7F_FFFF, 32'h7F7F_FFFF, 1'b1, {2'b10, 32'hFF80_0000}, "R7");
    issue(32'h0080_0000, 32'h0080_0001, 1'b1, {2'b01, 32'h8000_0000}, "R8");
    issue(32'h0000_0001, 32'h3F80_0000, 1'b0, {2'b00, 32'h3F80_0000}, "R8");
    issue(32'h007F_FFFF, 32'h807F_FFFF, 1'b1, {2'b00, 32'h0000_0000}, "R8");
    issue(32'h7F80_0000, 32'hFF80_0000, 1'b0, {2'b00, 32'h7FC0_0000}, "R9");
    issue(32'h7F80_0000, 32'h7F80_0000, 1'b1, {2'b00, 32'h7FC0_0000}, "R9");
    issue(32'h3F80_0000, 32'h7F80_0000, 1'b1, {2'b00, 32'hFF80_0000}, "R9");
    issue(32'h7F80_0001, 32'h3F80_0000, 1'b0, {2'b00, 32'h7FC0_0001}, "R9");
    issue(32'h3F80_0000, 32'hFF80_0005, 1'b0, {2'b00, 32'hFFC0_0005}, "R9");
    idle(6);

    // random traffic with gaps, close exponents and full-range words
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] a, b;
      logic s;
      a = $urandom; b = $urandom; s = 1'($urandom);
      if (i % 3 != 0) begin
        int eb;
        eb = int'(a[30:23]) + $signed($urandom_range(0, 60)) - 30;
        if (eb < 1) eb = 1;
        if (eb > 254) eb = 254;
        b[30:23] = 8'(eb);
      end
      if (i % 7 == 0) b = {~a[31], a[30:0]};
      if (($urandom & 3) == 0) idle(1 + ($urandom & 3));
      issue(a, b, s, refAdd(a, b, s), s ? "R4" : "R3");
    end
    idle(8);
    done = 1'b1;
    if (expQ.size() != 0) begin
      compared++;
      mismatched++;
      $display("FAIL R1: %0d results missing, expected 0", expQ.size());
    end
    finishRun();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    done = 1'b1;
    compared++;
    mismatched++;
    $display("FAIL R1: watchdog expired at cycle %0d expected completion", cyc);
    finishRun();
  end
endmodule